// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller collects coins toward a fixed price of one dollar. Three strobe inputs each report one coin: a 25-cent piece, a one-dollar coin and a two-dollar coin. At most one strobe is expected per clock. Credit below the price is kept as a count of 25-cent steps: 0, 25, 50 or 75 cents.

On the clock edge that samples a coin which brings the total to the price or past it, the controller raises a one-cycle vend pulse. On that same edge it also drives the number of 25-cent coins owed back to the customer, and it clears its credit to zero. A large coin arriving on top of a partial credit can overshoot the price, so the returned count runs from 0 to 7 and fits a 3-bit bus.

Top module: `coin_vendor`

## Requirements
- R1: A synchronous active-high `rst` clears the credit to zero and drives `vend` to 0 and `refund_q` to 0 on the next clock edge.
- R2: A 25-cent strobe (`coin_q`) adds 25 cents to a credit of 0, 25 or 50 cents. It leaves `vend` and `refund_q` at 0.
- R3: When a sampled coin brings the credit plus the coin value to 100 cents or more, `vend` is 1 after the same clock edge that samples the coin.
- R4: On a vend cycle, `refund_q` equals (credit + coin value − 100) / 25, as an unsigned binary count of 25-cent coins.
- R5: After a vend the credit is zero, so the next sale again needs a full 100 cents.
- R6: `vend` and `refund_q` hold a sale for one cycle only. On every cycle without a completed sale both are 0. Back-to-back sales give back-to-back pulses.
- R7: When several strobes are high in one cycle, only one coin is credited, with priority two-dollar (`coin_two`), then one-dollar (`coin_one`), then 25-cent (`coin_q`).
- R8: A cycle with no strobe leaves the credit unchanged and produces no sale.
- R9: A two-dollar coin on a 75-cent credit gives the largest change, 7. A one-dollar coin on zero credit vends with a change of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coin_q | input | 1 | One 25-cent coin accepted this cycle |
| coin_one | input | 1 | One one-dollar coin accepted this cycle |
| coin_two | input | 1 | One two-dollar coin accepted this cycle |
| vend | output | 1 | Registered one-cycle pulse that releases the item |
| refund_q | output | 3 | Registered count of 25-cent coins to return, valid while `vend` is high |

## Verification
The assertions take the strobes as stable between rising edges. They do not assume the strobes are mutually exclusive, because the priority rule defines what happens when several are high, and the properties are written to hold under that rule. The stimulus changes inputs a short time after each rising edge. It runs directed sequences for every credit level with each coin type. It then adds a pseudo-random phase in which any combination of strobes, including all three together, can occur with idle gaps between them. Reset is also applied while credit is held, so every state reaches every input.

// File: rtl/coin_vendor.sv
module coin_vendor #(
  parameter int PRICE_Q  = 4,
  parameter int ONE_Q    = 4,
  parameter int TWO_Q    = 8,
  parameter int CREDIT_W = 2,
  parameter int CHANGE_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coin_q,
  input  logic                coin_one,
  input  logic                coin_two,
  output logic                vend,
  output logic [CHANGE_W-1:0] refund_q
);
  localparam int SUM_W = CHANGE_W + 1;

  logic [CREDIT_W-1:0] credit;
  logic [SUM_W-1:0]    coin_val;
  logic [SUM_W-1:0]    total;
  logic                paid;

  assign coin_val = coin_two ? SUM_W'(TWO_Q) :
                    coin_one ? SUM_W'(ONE_Q) :
                    coin_q   ? SUM_W'(1)     : '0;
  assign total = SUM_W'(credit) + coin_val;
  assign paid  = total >= SUM_W'(PRICE_Q);

  always_ff @(posedge clk) begin
    if (rst) begin
      credit   <= '0;
      vend     <= 1'b0;
      refund_q <= '0;
    end else if (paid) begin
      credit   <= '0;
      vend     <= 1'b1;
      refund_q <= CHANGE_W'(total - SUM_W'(PRICE_Q));
    end else begin
      credit   <= CREDIT_W'(total);
      vend     <= 1'b0;
      refund_q <= '0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!vend && refund_q == '0 && credit == '0)); // R1
  AST_QUARTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (coin_q && !coin_one && !coin_two && credit != '1) |=> (!vend && credit == $past(credit) + 1'b1)); // R2
  AST_ONE_VENDS: assert property (@(posedge clk) disable iff (rst)
    (coin_one && !coin_two) |=> (vend && credit == '0)); // R3
  AST_TWO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    coin_two |=> (vend && refund_q >= CHANGE_W'(TWO_Q - PRICE_Q))); // R7
  AST_NO_CHANGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !vend |-> refund_q == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!coin_q && !coin_one && !coin_two) |=> (!vend && credit == $past(credit))); // R8
  AST_SALE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    vend |-> credit == '0); // R5
endmodule

// File: tb/coin_vendor_bench.sv
module coin_vendor_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_q = 1'b0, coin_one = 1'b0, coin_two = 1'b0;
  logic       vend;
  logic [2:0] refund_q;

  int    n_cmp = 0, n_bad = 0;
  int    credit_c = 0;
  int    exp_vend = 0, exp_chg = 0;
  bit    started = 1'b0, done = 1'b0;
  string tag = "R1";

  coin_vendor u_coin_vendor (
    .clk(clk), .rst(rst), .coin_q(coin_q), .coin_one(coin_one), .coin_two(coin_two),
    .vend(vend), .refund_q(refund_q)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int val, t;
    started <= 1'b1;
    if (rst) begin
      credit_c = 0; exp_vend <= 0; exp_chg <= 0;
    end else begin
      val = coin_two ? 200 : coin_one ? 100 : coin_q ? 25 : 0;
      t = credit_c + val;
      if (t >= 100) begin
        exp_vend <= 1; exp_chg <= (t - 100) / 25; credit_c = 0;
      end else begin
        exp_vend <= 0; exp_chg <= 0; credit_c = t;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (int'(vend) != exp_vend || int'(refund_q) != exp_chg) begin
        n_bad++;
        $display("FAIL %s: vend=%0d refund=%0d expected vend=%0d refund=%0d at %0t",
                 tag, vend, refund_q, exp_vend, exp_chg, $time);
      end
    end
  end

  task automatic drive(input bit q, input bit one, input bit two);
    @(posedge clk); #2;
    coin_q = q; coin_one = one; coin_two = two;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  task automatic quarters(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0);
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    tag = "R2"; quarters(3); idle(1);
    tag = "R3"; quarters(1); idle(2);
    tag = "R4"; quarters(2); drive(0, 1, 0); idle(1);
    tag = "R9"; quarters(3); drive(0, 0, 1); idle(1);
    tag = "R9"; drive(0, 1, 0); idle(1);
    tag = "R4"; quarters(1); drive(0, 0, 1); idle(1);
    tag = "R6"; drive(0, 1, 0); drive(0, 1, 0); drive(0, 0, 1); idle(2);
    tag = "R5"; quarters(2); drive(0, 1, 0); quarters(3); idle(1); quarters(1); idle(1);
    tag = "R8"; quarters(1); idle(5); quarters(1); idle(4); quarters(2); idle(1);
    tag = "R7"; drive(1, 1, 1); drive(1, 1, 0); drive(1, 0, 1); idle(1);
    quarters(1); drive(1, 1, 0); quarters(3); drive(1, 0, 1); idle(1);
    tag = "R1"; quarters(3); drive(0, 0, 0); #0 rst = 1'b1; idle(2); rst = 1'b0;
    quarters(3); idle(1); quarters(1); idle(1);
    tag = "R6";
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[7:5] == 3'd0) drive(1, 1, 1);
      else if (lfsr[1:0] == 2'd3) drive(0, lfsr[4], lfsr[6]);
      else drive(lfsr[2], 0, 0);
    end
    idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule